// File: doc/BRIEF.md
# Voice Codec Receive Byte Queue

This block buffers bytes that a codec deserializer produces and holds them until a host reads them. Bytes enter through a valid/ready write port and leave through a valid/ready read port in arrival order. The read side is show-ahead: the oldest byte is always visible on the read data pins while the queue holds anything. The host also sees several status pins: empty, exactly-one-left and full flags, and the current number of stored bytes.

A programmable fill mark raises a sticky interrupt status bit when the fill count climbs to or past the mark. A separate enable bit gates that status onto the interrupt pin. Software clears the status by pulsing a clear input. A one-shot flush request empties the queue. The flush is seen as a busy bit that is high for exactly one cycle and then drops by itself.

Back-pressure works as follows. A write is taken on a clock edge when `wr_valid` and `wr_ready` are both high. `wr_ready` is low while the queue is full or a flush is in progress. A read is taken when `rd_valid` and `rd_ready` are both high. `rd_valid` is low while the queue is empty or a flush is in progress. A producer may hold `wr_valid` high for as long as it needs to. Nothing is lost or duplicated while ready is low.

Top module: `voice_rx_fifo`

## Requirements
- R1: `lvl` gives the number of stored bytes (0 to DEPTH, with DEPTH = 16 by default, in a 5-bit field). `is_empty` is 1 exactly when `lvl` is 0. `is_full` is 1 exactly when `lvl` equals DEPTH.
- R2: `one_left` is 1 exactly when `lvl` equals 1.
- R3: Accepted bytes come out in the order they were written. `rd_data` shows the oldest byte whenever `rd_valid` is 1. `wr_ready` is 0 while full. `rd_valid` is 1 whenever the queue is not empty and no flush is in progress.
- R4: A write offered while full and a read requested while empty are ignored. `lvl` and the stored contents stay unchanged.
- R5: A write and a read taken on the same edge leave `lvl` unchanged.
- R6: A one-cycle pulse on `flush_wr` makes `flush_busy` 1 for exactly the next cycle. During that cycle `wr_ready` and `rd_valid` are 0. From the following cycle on, the queue is empty with `lvl` 0 and `flush_busy` back at 0.
- R7: `irq_stat` becomes 1 one cycle after `lvl` moves from below `mark` to greater than or equal to `mark`. A `mark` of 0 never sets it.
- R8: `irq_stat` stays 1 until a pulse on `stat_clr`. After the clear it stays 0 while `lvl` remains at or above `mark`, and it is set again only on a new upward crossing.
- R9: `irq` is 1 exactly when `irq_stat` and `irq_en` are both 1. While `irq_en` is 0, `irq` stays 0.
- R10: After reset, `lvl` is 0, `is_empty` is 1, and `one_left`, `is_full`, `irq_stat`, `irq` and `flush_busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Producer offers a byte |
| wr_ready | output | 1 | Queue can take a byte |
| wr_data | input | 8 | Byte offered |
| rd_valid | output | 1 | A byte is available |
| rd_ready | input | 1 | Host takes the byte |
| rd_data | output | 8 | Oldest stored byte |
| mark | input | 5 | Fill mark for the interrupt condition, 0 disables |
| irq_en | input | 1 | Interrupt enable |
| stat_clr | input | 1 | Pulse: clear interrupt status |
| flush_wr | input | 1 | Pulse: empty the queue |
| flush_busy | output | 1 | Self-clearing flush bit |
| is_empty | output | 1 | No byte stored |
| one_left | output | 1 | Exactly one byte stored |
| is_full | output | 1 | DEPTH bytes stored |
| lvl | output | 5 | Stored byte count |
| irq_stat | output | 1 | Sticky interrupt status |
| irq | output | 1 | Gated interrupt output |

## Verification
The bench builds the block with its defaults, DEPTH 16 and 8-bit data. With these values the 5-bit count field has to reach exactly 16, which brings the full boundary and the rejected write at full within a short run. A mark of 5 is used so the crossing, the clear, the re-arm and a same-edge read plus write can all happen below full. A mark of 0 is held through a complete fill to show that it never sets the status.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  typedef struct packed {
    logic empty;
    logic one;
    logic full;
  } vrf_flags_t;

  function automatic int unsigned vrf_addr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/vrf_store.sv
module vrf_store #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/vrf_ctrl.sv
module vrf_ctrl
  import vrf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4,
  parameter int unsigned LW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          clear,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [LW-1:0] count,
  output vrf_flags_t    flags
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [LW-1:0] TOP  = LW'(DEPTH);
  localparam logic [LW-1:0] ONE  = LW'(1);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (clear) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else begin
      unique case ({push, pop})
        2'b10:   count <= count + ONE;
        2'b01:   count <= count - ONE;
        default: count <= count;
      endcase
    end
  end

  always_comb begin
    flags.empty = (count == '0);
    flags.one   = (count == ONE);
    flags.full  = (count == TOP);
  end
endmodule

// File: rtl/vrf_irq.sv
module vrf_irq #(
  parameter int unsigned LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] count,
  input  logic [LW-1:0] mark,
  input  logic          en,
  input  logic          clr,
  output logic          stat,
  output logic          irq
);
  logic hit, hit_q;

  assign hit = (mark != '0) && (count >= mark);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      stat  <= 1'b0;
    end else begin
      hit_q <= hit;
      if (hit && !hit_q) stat <= 1'b1;
      else if (clr)      stat <= 1'b0;
    end
  end

  assign irq = stat & en;
endmodule

// File: rtl/voice_rx_fifo.sv
module voice_rx_fifo
  import vrf_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_valid,
  output logic                         wr_ready,
  input  logic [DW-1:0]                wr_data,
  output logic                         rd_valid,
  input  logic                         rd_ready,
  output logic [DW-1:0]                rd_data,
  input  logic [$clog2(DEPTH+1)-1:0]   mark,
  input  logic                         irq_en,
  input  logic                         stat_clr,
  input  logic                         flush_wr,
  output logic                         flush_busy,
  output logic                         is_empty,
  output logic                         one_left,
  output logic                         is_full,
  output logic [$clog2(DEPTH+1)-1:0]   lvl,
  output logic                         irq_stat,
  output logic                         irq
);
  localparam int unsigned AW = vrf_addr_bits(DEPTH);
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic [AW-1:0] wptr, rptr;
  vrf_flags_t    flags;
  logic          push, pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_busy <= 1'b0;
    else        flush_busy <= flush_wr;
  end

  assign wr_ready = !flags.full  && !flush_busy;
  assign rd_valid = !flags.empty && !flush_busy;
  assign push     = wr_valid && wr_ready;
  assign pop      = rd_valid && rd_ready;

  vrf_ctrl #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .clear (flush_busy),
    .wptr  (wptr),
    .rptr  (rptr),
    .count (lvl),
    .flags (flags)
  );

  vrf_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk   (clk),
    .we    (push),
    .waddr (wptr),
    .wdata (wr_data),
    .raddr (rptr),
    .rdata (rd_data)
  );

  vrf_irq #(.LW(LW)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .count (lvl),
    .mark  (mark),
    .en    (irq_en),
    .clr   (stat_clr),
    .stat  (irq_stat),
    .irq   (irq)
  );

  assign is_empty = flags.empty;
  assign one_left = flags.one;
  assign is_full  = flags.full;
endmodule

// File: rtl/vrf_chk.sv
module vrf_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          flush_busy,
  input logic          stat_clr,
  input logic          irq_en,
  input logic          is_full,
  input logic          one_left,
  input logic [LW-1:0] lvl,
  input logic [LW-1:0] mark,
  input logic          irq_stat,
  input logic          irq
);
  localparam logic [LW-1:0] TOP = LW'(DEPTH);

  p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= TOP);

  p_one_left_r2: assert property (@(posedge clk) disable iff (!rst_n)
    one_left |-> (rd_valid || flush_busy));

  p_push_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !(rd_valid && rd_ready)) |=> (lvl == $past(lvl) + LW'(1)));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && !(rd_valid && rd_ready) && !flush_busy) |=> is_full);

  p_both_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && rd_valid && rd_ready) |=> $stable(lvl));

  p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |=> (lvl == '0));

  p_stat_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_stat) |-> ($past(mark) != '0 && $past(lvl) >= $past(mark)));

  p_stat_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stat && !stat_clr) |=> irq_stat);

  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

bind voice_rx_fifo vrf_chk #(.DEPTH(DEPTH), .LW($clog2(DEPTH+1))) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .flush_busy (flush_busy),
  .stat_clr   (stat_clr),
  .irq_en     (irq_en),
  .is_full    (is_full),
  .one_left   (one_left),
  .lvl        (lvl),
  .mark       (mark),
  .irq_stat   (irq_stat),
  .irq        (irq)
);

// File: tb/sim_voice_rx_fifo.sv
`timescale 1ns/1ps
module sim_voice_rx_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, rd_ready = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready, rd_valid, flush_busy;
  logic [7:0] rd_data;
  logic [4:0] mark = '0, lvl;
  logic       irq_en = 1'b0, stat_clr = 1'b0, flush_wr = 1'b0;
  logic       is_empty, one_left, is_full, irq_stat, irq;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q [$];

  always #10 clk = ~clk;

  voice_rx_fifo u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .mark(mark), .irq_en(irq_en), .stat_clr(stat_clr),
    .flush_wr(flush_wr), .flush_busy(flush_busy), .is_empty(is_empty),
    .one_left(one_left), .is_full(is_full), .lvl(lvl),
    .irq_stat(irq_stat), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    if (wr_ready) exp_q.push_back(d);
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic pop_n(input int n);
    @(posedge clk); #1;
    rd_ready = 1'b1;
    repeat (n) @(posedge clk);
    #1 rd_ready = 1'b0;
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  // monitor: compare every byte the host takes against the scoreboard (R3)
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      if (exp_q.size() == 0) chk("R3 unexpected read", {24'h0, rd_data}, 32'hFFFF);
      else chk("R3 order", {24'h0, rd_data}, {24'h0, exp_q.pop_front()});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 lvl", lvl, 0);
    chk("R10 is_empty", is_empty, 1);
    chk("R10 one_left", one_left, 0);
    chk("R10 is_full", is_full, 0);
    chk("R10 irq_stat", irq_stat, 0);
    chk("R10 irq", irq, 0);
    chk("R10 flush_busy", flush_busy, 0);
    rst_n = 1'b1;
    tick();

    push(8'h11);
    chk("R1 lvl one", lvl, 1);
    chk("R2 one_left", one_left, 1);
    chk("R1 not empty", is_empty, 0);
    chk("R3 show-ahead", rd_data, 8'h11);
    chk("R3 rd_valid", rd_valid, 1);
    for (int i = 1; i < 16; i++) push(8'h20 + 8'(i));
    chk("R1 lvl full", lvl, 16);
    chk("R1 is_full", is_full, 1);
    chk("R3 wr_ready low at full", wr_ready, 0);
    chk("R2 one_left off", one_left, 0);
    tick();
    chk("R7 mark zero never sets", irq_stat, 0);
    push(8'hEE);
    chk("R4 write at full ignored", lvl, 16);
    pop_n(16);
    chk("R1 empty after drain", is_empty, 1);
    chk("R3 all drained", exp_q.size(), 0);
    pop_n(3);
    chk("R4 read at empty ignored", lvl, 0);
    chk("R4 rd_valid low when empty", rd_valid, 0);

    mark = 5'd5;
    for (int i = 0; i < 4; i++) push(8'h40 + 8'(i));
    tick();
    chk("R7 below mark", irq_stat, 0);
    push(8'h44);
    tick();
    chk("R7 crossing sets", irq_stat, 1);
    chk("R9 gated off", irq, 0);
    irq_en = 1'b1; #1;
    chk("R9 gated on", irq, 1);

    stat_clr = 1'b1; tick(); stat_clr = 1'b0;
    chk("R8 clear", irq_stat, 0);
    tick();
    chk("R8 no reset while above mark", irq_stat, 0);
    chk("R9 follows status", irq, 0);
    pop_n(1);
    chk("R1 lvl four", lvl, 4);
    push(8'h55);
    tick();
    chk("R7 re-arm crossing", irq_stat, 1);
    tick();
    chk("R8 sticky", irq_stat, 1);

    @(posedge clk); #1;
    wr_valid = 1'b1; wr_data = 8'h66; rd_ready = 1'b1;
    @(negedge clk);
    if (wr_ready) exp_q.push_back(8'h66);
    @(posedge clk); #1;
    wr_valid = 1'b0; rd_ready = 1'b0;
    chk("R5 push and pop same edge", lvl, 5);

    @(posedge clk); #1 flush_wr = 1'b1;
    @(posedge clk); #1 flush_wr = 1'b0;
    chk("R6 flush_busy high", flush_busy, 1);
    chk("R6 wr_ready low in flush", wr_ready, 0);
    chk("R6 rd_valid low in flush", rd_valid, 0);
    tick();
    exp_q.delete();
    chk("R6 flush_busy self-clears", flush_busy, 0);
    chk("R6 lvl zero", lvl, 0);
    chk("R6 empty", is_empty, 1);

    push(8'h71);
    push(8'h72);
    chk("R6 refill count", lvl, 2);
    pop_n(2);
    chk("R3 refill drained", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule